// File: doc/BRIEF.md
# Soft Mute Ramp Attenuator

This block fades a stereo stream of 24-bit two's complement samples down to silence and back up again, entirely in the digital domain. It is used to switch audio sources without clicks. The samples keep flowing the whole time, and only their amplitude is scaled. A gain counter moves one step on every sample strobe. It falls toward zero while mute is requested and climbs back toward unity when the request is withdrawn. A full fade takes `RAMP_STEPS` sample periods, which is 1024 by default.

When the request flips part way through a fade, the counter turns around from the level it has reached, so the output never jumps. The return to unity then takes exactly as many samples as the fade had already spent. The mute request may come from any clock domain. It is resynchronised, and only its value at a sample strobe matters. A status output reports when the stream is fully silenced.

Top module: `soft_mute_ramp`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_left`, `out_right`, `out_valid` and `muted` are 0, and the gain counter starts at its maximum value `RAMP_STEPS-1`.
- R2: Each output sample is registered one clock after its strobe, and `out_valid` is high for exactly that one cycle. If the gain before the strobe is `RAMP_STEPS-1` and the sampled mute is 0, the output equals the input bit for bit.
- R3: On each strobe with the sampled mute at 1, the gain counter decreases by one. The output for that strobe is `input * g / RAMP_STEPS`, where `g` is the gain before the strobe.
- R4: On each strobe with the sampled mute at 0, the gain counter increases by one, up to `RAMP_STEPS-1`.
- R5: A mute change in the middle of a fade reverses the direction from the current gain with no jump: the gain moves by at most one per strobe. The return to unity takes as many strobes as the fade had spent.
- R6: The gain counter saturates: it stays at 0 while muted and at `RAMP_STEPS-1` while unmuted.
- R7: `muted` is 1 exactly while the gain counter is 0. It changes only on the cycle after a strobe.
- R8: A sample scaled with gain 0 is output as exactly 000000h.
- R9: Between strobes the gain, the output samples and `muted` hold their values. A mute pulse that starts and ends between two strobes has no effect.
- R10: The scaling rounds toward zero. A negative sample gives the negative of the result for its magnitude. For example, -1 at any gain below the maximum gives 0.
- R11: `mute_req` passes through `SYNC_STAGES` flip-flops, 2 by default. A change made less than two clocks before a strobe is not seen by that strobe, and the strobe uses the earlier value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mute_req | input | 1 | Mute request, asynchronous to `clk` |
| smp_valid | input | 1 | Sample strobe, one cycle per stereo sample |
| in_left | input | DATA_W | Left input sample, two's complement |
| in_right | input | DATA_W | Right input sample, two's complement |
| out_left | output | DATA_W | Attenuated left sample |
| out_right | output | DATA_W | Attenuated right sample |
| out_valid | output | 1 | High for one cycle when a new output pair is present |
| muted | output | 1 | High while the gain is zero |

## Verification
The bench builds the block with its default parameters: 24-bit samples, a ramp of 1024 steps and a two-stage synchroniser. It therefore drives the full-length fades described by the requirements: a complete descent to silence, saturation at both ends, and a complete climb back. It also runs a reversal at gain 723 and a long stretch of randomly toggled mute requests. The gain width of 10 bits exposes the extreme products, such as 800000h times 1023, and truncation toward zero of negative values. The synchroniser depth of two lets a directed case place a mute edge one clock before a strobe, where that strobe must still use the earlier value.

// File: rtl/smr_pkg.sv
package smr_pkg;

  // Direction the gain counter takes on a strobe
  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_DOWN = 2'd1,
    RAMP_UP   = 2'd2
  } ramp_dir_e;

endpackage

// File: rtl/smr_sync.sv
module smr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/smr_gain_ctrl.sv
module smr_gain_ctrl
  import smr_pkg::*;
#(
  parameter int GAIN_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              mute_s,
  output logic [GAIN_W-1:0] gain,
  output logic              bypass,
  output logic              muted
);

  localparam logic [GAIN_W-1:0] GAIN_MAX  = '1;
  localparam logic [GAIN_W-1:0] GAIN_ZERO = '0;

  ramp_dir_e         dir;
  logic [GAIN_W-1:0] gain_nxt;

  // Pick the step direction; the ends of the range clamp to hold
  always_comb begin
    if (mute_s && (gain != GAIN_ZERO))      dir = RAMP_DOWN;
    else if (!mute_s && (gain != GAIN_MAX)) dir = RAMP_UP;
    else                                    dir = RAMP_HOLD;
  end

  always_comb begin
    unique case (dir)
      RAMP_DOWN: gain_nxt = gain - 1'b1;
      RAMP_UP:   gain_nxt = gain + 1'b1;
      default:   gain_nxt = gain;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain  <= GAIN_MAX;
      muted <= 1'b0;
    end else if (strobe) begin
      gain  <= gain_nxt;
      muted <= (gain_nxt == GAIN_ZERO);
    end
  end

  // Unity and not muting: pass samples through untouched
  assign bypass = (gain == GAIN_MAX) && !mute_s;

endmodule

// File: rtl/smr_scale.sv
module smr_scale #(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              bypass,
  input  logic [GAIN_W-1:0] gain,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam int PROD_W = DATA_W + GAIN_W;

  logic              neg;
  logic [DATA_W-1:0] mag;
  logic [PROD_W-1:0] prod;
  logic [DATA_W-1:0] mag_scaled;
  logic [DATA_W-1:0] scaled;
  logic              unused_lo;

  // Work on the magnitude so the shift truncates toward zero
  assign neg        = din[DATA_W-1];
  assign mag        = neg ? (~din + 1'b1) : din;
  assign prod       = PROD_W'(mag) * PROD_W'(gain);
  assign mag_scaled = prod[PROD_W-1:GAIN_W];
  assign scaled     = neg ? (~mag_scaled + 1'b1) : mag_scaled;
  assign unused_lo  = ^prod[GAIN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (load) dout <= bypass ? din : scaled;
  end

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
  parameter int DATA_W      = 24,
  parameter int RAMP_STEPS  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mute_req,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right,
  output logic              out_valid,
  output logic              muted
);

  localparam int GAIN_W = $clog2(RAMP_STEPS);
  localparam int NUM_CH = 2;

  logic              mute_s;
  logic [GAIN_W-1:0] gain_q;
  logic              bypass;

  logic [NUM_CH-1:0][DATA_W-1:0] ch_in;
  logic [NUM_CH-1:0][DATA_W-1:0] ch_out;

  smr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (mute_req),
    .q   (mute_s)
  );

  smr_gain_ctrl #(.GAIN_W(GAIN_W)) u_gain (
    .clk    (clk),
    .rst    (rst),
    .strobe (smp_valid),
    .mute_s (mute_s),
    .gain   (gain_q),
    .bypass (bypass),
    .muted  (muted)
  );

  assign ch_in[0] = in_left;
  assign ch_in[1] = in_right;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      smr_scale #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_scale (
        .clk    (clk),
        .rst    (rst),
        .load   (smp_valid),
        .bypass (bypass),
        .gain   (gain_q),
        .din    (ch_in[c]),
        .dout   (ch_out[c])
      );
    end
  endgenerate

  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= smp_valid;
  end

endmodule

// File: rtl/smr_checker.sv
module smr_checker #(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_valid,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_left,
  input logic [DATA_W-1:0] out_right,
  input logic              muted,
  input logic [GAIN_W-1:0] gain
);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> out_valid);

  assert_valid_single_R2: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> !out_valid);

  assert_no_jump_R5: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> ((int'(gain) - int'($past(gain)) <= 1) &&
                   (int'($past(gain)) - int'(gain) <= 1)));

  assert_hold_between_R9: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> ($stable(gain) && $stable(out_left) &&
                    $stable(out_right) && $stable(muted)));

  assert_muted_tracks_R7: assert property (@(posedge clk) disable iff (rst)
    muted == (gain == '0));

  assert_muted_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(muted) |-> $past(smp_valid));

  assert_zero_out_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(muted)) |-> (out_left == '0 && out_right == '0));

endmodule

bind soft_mute_ramp smr_checker #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .smp_valid (smp_valid),
  .out_valid (out_valid),
  .out_left  (out_left),
  .out_right (out_right),
  .muted     (muted),
  .gain      (gain_q)
);

// File: tb/test_soft_mute_ramp.sv
`timescale 1ns/1ps
module test_soft_mute_ramp;

  localparam int DW   = 24;
  localparam int GMAX = 1023;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mute_req = 1'b0;
  logic          smp_valid = 1'b0;
  logic [DW-1:0] in_left = '0;
  logic [DW-1:0] in_right = '0;
  logic [DW-1:0] out_left;
  logic [DW-1:0] out_right;
  logic          out_valid;
  logic          muted;

  int checks = 0;
  int errors = 0;
  int g_m    = GMAX;
  bit eff_m  = 1'b0;

  always #2.5 clk = ~clk;

  soft_mute_ramp i_soft_mute_ramp (
    .clk(clk), .rst(rst), .mute_req(mute_req), .smp_valid(smp_valid),
    .in_left(in_left), .in_right(in_right), .out_left(out_left),
    .out_right(out_right), .out_valid(out_valid), .muted(muted)
  );

  function automatic logic [DW-1:0] ref_scale(logic [DW-1:0] x, int g, bit m);
    longint v, q;
    if (g == GMAX && !m) return x;
    v = longint'($signed(x));
    q = ((v < 0 ? -v : v) * g) >> 10;
    return DW'(v < 0 ? -q : q);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one stereo sample; early=1 lets the synchroniser settle first
  task automatic put(bit m, bit early, logic [DW-1:0] l, logic [DW-1:0] r, string req);
    logic [DW-1:0] el, er;
    logic [DW-1:0] hl, hr;
    bit em;
    mute_req = m;
    if (early) begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      eff_m = m;
    end
    el = ref_scale(l, g_m, eff_m);
    er = ref_scale(r, g_m, eff_m);
    if (eff_m && g_m > 0) g_m--;
    else if (!eff_m && g_m < GMAX) g_m++;
    em = (g_m == 0);
    smp_valid = 1'b1; in_left = l; in_right = r;
    @(posedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
    chk(out_valid && out_left == el && out_right == er && muted == em, req,
        {out_valid, muted, out_left, out_right}, {1'b1, em, el, er});
    hl = out_left; hr = out_right;
    if (!early) eff_m = m;
    @(negedge clk);
    chk(!out_valid && out_left == hl && out_right == hr && muted == em, "R9 hold",
        {out_valid, muted, out_left}, {1'b0, em, hl});
  endtask

  function automatic logic [DW-1:0] rnd();
    return DW'($urandom);
  endfunction

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_left == 0 && out_right == 0 && !out_valid && !muted, "R1 in reset",
        {out_valid, muted, out_left}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_left == 0 && !out_valid && !muted, "R1 after reset", {out_valid, muted, out_left}, 0);

    // R2: unity bypass, including extreme values
    put(0, 1, 24'h7FFFFF, 24'h800000, "R2 bypass corners");
    for (int i = 0; i < 20; i++) put(0, 1, rnd(), rnd(), "R2 bypass");

    // R3/R6/R7/R8/R10: full fade down past zero
    put(1, 1, 24'h800000, 24'hFFFFFF, "R10 extreme/negative one");
    for (int i = 0; i < 1030; i++) put(1, 1, rnd(), rnd(), "R3/R6/R8 fade down");
    chk(g_m == 0 && muted, "R6 saturated at zero", muted, 1);

    // R4/R6: climb back to unity and stay there
    for (int i = 0; i < 1030; i++) put(0, 1, rnd(), rnd(), "R4/R6 fade up");

    // R5: reverse after 300 steps; exactly 300 steps back to bypass
    for (int i = 0; i < 300; i++) put(1, 1, rnd(), rnd(), "R5 partial down");
    for (int i = 0; i < 300; i++) put(0, 1, 24'hFFFFFF, 24'h000001, "R5/R10 return");
    put(0, 1, 24'h123456, 24'hABCDEF, "R5 back at unity");

    // R9: a short mute pulse between strobes does nothing
    mute_req = 1'b1;
    repeat (3) @(posedge clk);
    mute_req = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    put(0, 1, 24'h654321, 24'h9ABCDE, "R9 pulse ignored");

    // R11: mute raised one clock before a strobe is not yet seen
    @(negedge clk);
    put(1, 0, 24'h400000, 24'hC00000, "R11 late edge");
    put(1, 1, 24'h400000, 24'hC00000, "R11 next strobe");
    for (int i = 0; i < 5; i++) put(0, 1, rnd(), rnd(), "R4 recover");

    // Random mute toggling
    for (int i = 0; i < 1500; i++) begin
      bit m;
      m = (($urandom % 64) == 0) ? !eff_m : eff_m;
      put(m, 1, rnd(), rnd(), "R3/R4/R5 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule